// File: doc/BRIEF.md
# I2C Bus Stall Watchdog

This block listens passively to the clock and data lines of an I2C bus, samples them on the system clock, and detects a bus that has stopped making progress. It tracks whether the bus is busy, starting at a Start condition and ending at a Stop. While the bus is busy it measures how many system clocks pass between consecutive bus events. When one of those gaps grows longer than a programmable limit, it latches a timeout flag.

The flag stays set until software clears it by writing one. A single interrupt line is raised while the flag is set and the event-timeout enable is on. The enables are changed through two write-only views, one that sets bits and one that clears them. In both views the event-timeout enable sits at bit 24 and an SCL-timeout enable at bit 25. The block only stores the SCL-timeout enable, for a separate clock-low monitor that lives elsewhere.

Top module: `i2c_stall_watch`

## Requirements
- R1: Both lines pass through a two-flop synchronizer. A Start is SDA going high to low while SCL stays high, and a Stop is SDA going low to high while SCL stays high. `busBusy` is set by a Start, stays set across a repeated Start, and is cleared by a Stop. `busBusy` changes at the third rising clock edge after the raw line change.
- R2: Four events restart the elapsed-time counter: a Start, a Stop, a rising SCL edge and a falling SCL edge. An SDA change while SCL is low is not an event.
- R3: With an effective limit E, `evtTimeout` rises when a busy interval between events exceeds E clocks. If the last raw change is applied before rising edge 1, the flag is still 0 after edge E+3 and is 1 after edge E+4. Gaps of E clocks or fewer never set it.
- R4: While the bus is idle, the counter is held at zero and `evtTimeout` is never set, however long the idle time.
- R5: `evtTimeout` is sticky. A cycle with `statClrWr`=1 and `statClrBit`=1 clears it. With `statClrBit`=0 the flag is unchanged. If an expiry and a clear fall in the same cycle, the flag is set.
- R6: After the flag is cleared during a stall that is still going on, it does not set again until a new event occurs and a further full interval expires.
- R7: `evtIntEn` and `sclIntEn` reset to 0. A set-view write (`ienSetWr`=1) with a 1 at bit 24 sets `evtIntEn`, and with a 1 at bit 25 sets `sclIntEn`. Zero bits leave the enables unchanged.
- R8: A clear-view write (`ienClrWr`=1) with a 1 at bit 24 or bit 25 clears the matching enable, and zero bits leave it unchanged. When the set view and the clear view hit the same bit in the same cycle, the clear wins.
- R9: `irqOut` is 1 exactly when `evtTimeout` and `evtIntEn` are both 1.
- R10: A limit value of 0 behaves as a limit of 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclIn | input | 1 | Raw SCL line level |
| sdaIn | input | 1 | Raw SDA line level |
| limitVal | input | 16 | Longest permitted gap between events, in clocks |
| ienSetWr | input | 1 | Write strobe of the enable set view |
| ienSetData | input | 2 ([25:24]) | Set-view data, bit 24 event timeout, bit 25 SCL timeout |
| ienClrWr | input | 1 | Write strobe of the enable clear view |
| ienClrData | input | 2 ([25:24]) | Clear-view data, same bit positions |
| statClrWr | input | 1 | Write strobe of the status flag |
| statClrBit | input | 1 | Write data for the flag; 1 clears it |
| busBusy | output | 1 | Bus is between a Start and a Stop |
| evtTimeout | output | 1 | Sticky event-timeout flag |
| evtIntEn | output | 1 | Event-timeout interrupt enable |
| sclIntEn | output | 1 | Stored SCL-timeout interrupt enable |
| irqOut | output | 1 | Interrupt request |

## Verification
The hardest situation to reach from the ports is a flag cleared in the middle of a stall that is still going on. The bench has to let a stall expire, clear the flag while the lines stay frozen, and then watch for several limit lengths to see that the flag does not come back. The stalls are driven once with SCL held low and once with SCL held high. Each starts from an exactly known negative-edge change, so the set cycle can be checked to within one clock. Before the stalls, randomly timed transfer bits keep every gap within the limit and confirm that no false timeout occurs.

// File: rtl/stall_pkg.sv
package stall_pkg;
  localparam int EVT_EN_BIT = 24;
  localparam int SCL_EN_BIT = 25;

  typedef struct packed {
    logic startEv;
    logic stopEv;
    logic sclRise;
    logic sclFall;
    logic busy;
  } busStrobes_t;
endpackage

// File: rtl/stall_ctrl.sv
module stall_ctrl
  import stall_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sclIn,
  input  logic        sdaIn,
  output busStrobes_t strb
);
  logic [SYNC_STAGES-1:0] sclSync, sdaSync;
  logic sclNow, sdaNow, sclPrev, sdaPrev;
  logic busyQ, busyNext;
  logic sclSteadyHigh, startEv, stopEv;

  assign sclNow = sclSync[SYNC_STAGES-1];
  assign sdaNow = sdaSync[SYNC_STAGES-1];

  // synchronizer chains plus one history stage for edge detection
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
      busyQ   <= 1'b0;
    end else begin
      sclSync[0] <= sclIn;
      sdaSync[0] <= sdaIn;
      for (int i = 1; i < SYNC_STAGES; i++) begin
        sclSync[i] <= sclSync[i-1];
        sdaSync[i] <= sdaSync[i-1];
      end
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
      busyQ   <= busyNext;
    end
  end

  always_comb begin
    sclSteadyHigh = sclNow & sclPrev;
    startEv       = sclSteadyHigh & sdaPrev & ~sdaNow;
    stopEv        = sclSteadyHigh & ~sdaPrev & sdaNow;
    if (startEv)     busyNext = 1'b1;
    else if (stopEv) busyNext = 1'b0;
    else             busyNext = busyQ;
  end

  assign strb.startEv = startEv;
  assign strb.stopEv  = stopEv;
  assign strb.sclRise = sclNow & ~sclPrev;
  assign strb.sclFall = ~sclNow & sclPrev;
  assign strb.busy    = busyQ;
endmodule

// File: rtl/stall_dp.sv
module stall_dp
  import stall_pkg::*;
#(
  parameter int LIMIT_W = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  busStrobes_t                  strb,
  input  logic [LIMIT_W-1:0]           limitVal,
  input  logic                         ienSetWr,
  input  logic [SCL_EN_BIT:EVT_EN_BIT] ienSetData,
  input  logic                         ienClrWr,
  input  logic [SCL_EN_BIT:EVT_EN_BIT] ienClrData,
  input  logic                         statClrWr,
  input  logic                         statClrBit,
  output logic                         evtTimeout,
  output logic                         evtIntEn,
  output logic                         sclIntEn,
  output logic                         irqOut
);
  localparam int CNT_W = LIMIT_W + 1;
  localparam int EN_W  = SCL_EN_BIT - EVT_EN_BIT + 1;

  logic [CNT_W-1:0] gapCnt, effLimit;
  logic             restart, expire, flagQ;
  logic [EN_W-1:0]  enQ, setMask, clrMask;

  always_comb begin
    effLimit = (limitVal == '0) ? CNT_W'(1) : {1'b0, limitVal};
    restart  = strb.startEv | strb.stopEv | strb.sclRise | strb.sclFall;
    expire   = strb.busy & ~restart & (gapCnt == effLimit);
    setMask  = ienSetWr ? ienSetData : '0;
    clrMask  = ienClrWr ? ienClrData : '0;
  end

  // gap counter: cleared when idle or on an event, stops one past the limit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        gapCnt <= '0;
    else if (!strb.busy || restart)    gapCnt <= '0;
    else if (gapCnt <= effLimit)       gapCnt <= gapCnt + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        flagQ <= 1'b0;
    else if (expire)                   flagQ <= 1'b1;
    else if (statClrWr && statClrBit)  flagQ <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enQ <= '0;
    else        enQ <= (enQ | setMask) & ~clrMask;
  end

  assign evtTimeout = flagQ;
  assign evtIntEn   = enQ[0];
  assign sclIntEn   = enQ[EN_W-1];
  assign irqOut     = flagQ & enQ[0];
endmodule

// File: rtl/i2c_stall_watch.sv
module i2c_stall_watch
  import stall_pkg::*;
#(
  parameter int LIMIT_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         sclIn,
  input  logic                         sdaIn,
  input  logic [LIMIT_W-1:0]           limitVal,
  input  logic                         ienSetWr,
  input  logic [SCL_EN_BIT:EVT_EN_BIT] ienSetData,
  input  logic                         ienClrWr,
  input  logic [SCL_EN_BIT:EVT_EN_BIT] ienClrData,
  input  logic                         statClrWr,
  input  logic                         statClrBit,
  output logic                         busBusy,
  output logic                         evtTimeout,
  output logic                         evtIntEn,
  output logic                         sclIntEn,
  output logic                         irqOut
);
  busStrobes_t strb;

  stall_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn), .strb(strb)
  );

  stall_dp #(.LIMIT_W(LIMIT_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strb(strb), .limitVal(limitVal),
    .ienSetWr(ienSetWr), .ienSetData(ienSetData),
    .ienClrWr(ienClrWr), .ienClrData(ienClrData),
    .statClrWr(statClrWr), .statClrBit(statClrBit),
    .evtTimeout(evtTimeout), .evtIntEn(evtIntEn),
    .sclIntEn(sclIntEn), .irqOut(irqOut)
  );

  assign busBusy = strb.busy;
endmodule

// File: rtl/stall_watch_chk.sv
module stall_watch_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       busBusy,
  input logic       evtTimeout,
  input logic       evtIntEn,
  input logic       irqOut,
  input logic       ienSetWr,
  input logic [1:0] ienSetData,
  input logic       ienClrWr,
  input logic [1:0] ienClrData,
  input logic       statClrWr,
  input logic       statClrBit
);
  // R4
  idle_no_trip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busBusy && !evtTimeout) |=> !evtTimeout);

  // R5
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evtTimeout) |-> $past(statClrWr && statClrBit));

  // R7
  en_set_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evtIntEn) |-> $past(ienSetWr && ienSetData[0] && !(ienClrWr && ienClrData[0])));

  // R8
  en_clr_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(evtIntEn) |-> $past(ienClrWr && ienClrData[0]));

  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqOut) |-> ($rose(evtTimeout) || $rose(evtIntEn)));
endmodule

bind i2c_stall_watch stall_watch_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busBusy(busBusy), .evtTimeout(evtTimeout),
  .evtIntEn(evtIntEn), .irqOut(irqOut),
  .ienSetWr(ienSetWr), .ienSetData(ienSetData),
  .ienClrWr(ienClrWr), .ienClrData(ienClrData),
  .statClrWr(statClrWr), .statClrBit(statClrBit)
);

// File: tb/i2c_stall_watch_tb.sv
module i2c_stall_watch_tb;
  localparam int CLK_PERIOD = 10;
  localparam int LIM        = 20;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sclIn = 1'b1, sdaIn = 1'b1;
  logic [15:0] limitVal = 16'(LIM);
  logic        ienSetWr = 1'b0, ienClrWr = 1'b0;
  logic [25:24] ienSetData = '0, ienClrData = '0;
  logic        statClrWr = 1'b0, statClrBit = 1'b0;
  logic        busBusy, evtTimeout, evtIntEn, sclIntEn, irqOut;

  int checkCnt = 0;
  int failCnt  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_stall_watch u_dut (
    .clk(clk), .rst_n(rst_n), .sclIn(sclIn), .sdaIn(sdaIn), .limitVal(limitVal),
    .ienSetWr(ienSetWr), .ienSetData(ienSetData),
    .ienClrWr(ienClrWr), .ienClrData(ienClrData),
    .statClrWr(statClrWr), .statClrBit(statClrBit),
    .busBusy(busBusy), .evtTimeout(evtTimeout), .evtIntEn(evtIntEn),
    .sclIntEn(sclIntEn), .irqOut(irqOut)
  );

  function automatic logic tripExpected(input int gap, input int lim);
    int eff = (lim == 0) ? 1 : lim;
    return gap > eff;
  endfunction

  task automatic chk(input string tag, input logic act, input logic exp);
    checkCnt++;
    if (act !== exp) begin
      failCnt++;
      $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic hold(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wrSet(input logic [1:0] d);
    ienSetWr = 1'b1; ienSetData = d; hold(1); ienSetWr = 1'b0; ienSetData = '0;
  endtask

  task automatic wrClr(input logic [1:0] d);
    ienClrWr = 1'b1; ienClrData = d; hold(1); ienClrWr = 1'b0; ienClrData = '0;
  endtask

  task automatic wrStat(input logic b);
    statClrWr = 1'b1; statClrBit = b; hold(1); statClrWr = 1'b0; statClrBit = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    int seed;
    int a, b, h, worst;
    seed = $urandom(32'd1234);
    hold(3);
    rst_n = 1'b1;
    hold(2);
    // reset state (R7)
    chk("R7 reset evtIntEn", evtIntEn, 1'b0);
    chk("R7 reset sclIntEn", sclIntEn, 1'b0);
    chk("R5 reset flag", evtTimeout, 1'b0);
    chk("R1 reset busy", busBusy, 1'b0);
    chk("R9 reset irq", irqOut, 1'b0);

    // R4 long idle time, including SCL toggles without a Start
    sclIn = 1'b0; hold(3 * LIM); sclIn = 1'b1; hold(3 * LIM);
    chk("R4 idle no timeout", evtTimeout, 1'b0);

    // R7 / R8 enable views
    wrSet(2'b00);
    chk("R7 zero write no effect", evtIntEn, 1'b0);
    wrSet(2'b01);
    chk("R7 set bit24", evtIntEn, 1'b1);
    wrSet(2'b10);
    chk("R7 set bit25", sclIntEn, 1'b1);
    wrClr(2'b00);
    chk("R8 zero clear no effect", sclIntEn, 1'b1);
    wrClr(2'b10);
    chk("R8 clear bit25", sclIntEn, 1'b0);
    chk("R8 bit24 kept", evtIntEn, 1'b1);

    // R1 Start
    sdaIn = 1'b0;
    hold(2);
    chk("R1 busy not yet", busBusy, 1'b0);
    hold(1);
    chk("R1 busy after start", busBusy, 1'b1);

    // R2 / R3 random bits, every gap within the limit
    worst = 0;
    for (int i = 0; i < 40; i++) begin
      a = 1 + int'($urandom % (LIM / 2));
      b = 1 + int'($urandom % (LIM / 2));
      h = 1 + int'($urandom % LIM);
      sclIn = 1'b0; hold(a);
      sdaIn = 1'($urandom % 2); hold(b);
      sclIn = 1'b1; hold(h);
      if (a + b > worst) worst = a + b;
      if (h > worst) worst = h;
    end
    chk("R2 random transfer no trip", evtTimeout, tripExpected(worst, LIM));
    // R2 directed: exact-limit gaps, sda moving while scl low is not an event
    sclIn = 1'b0; hold(LIM / 2); sdaIn = ~sdaIn; hold(LIM - LIM / 2);
    sclIn = 1'b1; hold(LIM);
    chk("R2 gap equal to limit", evtTimeout, tripExpected(LIM, LIM));

    // R3 stall with SCL low, exact cycle; R9 irq with enable on
    sclIn = 1'b0;
    hold(LIM + 3);
    chk("R3 scl-low stall edge E+3", evtTimeout, 1'b0);
    hold(1);
    chk("R3 scl-low stall edge E+4", evtTimeout, 1'b1);
    chk("R9 irq with enable", irqOut, 1'b1);

    // R5 sticky and clear; R6 no re-set during same stall
    wrStat(1'b0);
    chk("R5 zero write keeps flag", evtTimeout, 1'b1);
    wrStat(1'b1);
    chk("R5 clear by one", evtTimeout, 1'b0);
    hold(3 * LIM);
    chk("R6 no re-set in same stall", evtTimeout, 1'b0);
    chk("R9 irq low after clear", irqOut, 1'b0);

    // R3 stall with SCL high, enable removed; R9 irq masked
    sclIn = 1'b1;
    wrClr(2'b01);
    hold(LIM + 2);
    chk("R3 scl-high stall edge E+3", evtTimeout, 1'b0);
    hold(1);
    chk("R3 scl-high stall edge E+4", evtTimeout, 1'b1);
    chk("R9 irq masked", irqOut, 1'b0);
    chk("R8 bit24 cleared", evtIntEn, 1'b0);
    wrStat(1'b1);

    // R8 clear wins over set in the same cycle
    ienSetWr = 1'b1; ienSetData = 2'b01; ienClrWr = 1'b1; ienClrData = 2'b01;
    hold(1);
    ienSetWr = 1'b0; ienClrWr = 1'b0; ienSetData = '0; ienClrData = '0;
    chk("R8 clear wins", evtIntEn, 1'b0);

    // R1 / R2 repeated Start restarts the counter and keeps busy
    sclIn = 1'b0; hold(2); sdaIn = 1'b1; hold(2); sclIn = 1'b1; hold(2);
    sdaIn = 1'b0;
    hold(LIM + 3);
    chk("R1 busy across repeated start", busBusy, 1'b1);
    chk("R2 repeated start restart E+3", evtTimeout, 1'b0);
    hold(1);
    chk("R2 repeated start restart E+4", evtTimeout, 1'b1);
    wrStat(1'b1);

    // R1 Stop, then R4 long idle
    sclIn = 1'b0; hold(2); sclIn = 1'b1; hold(2);
    sdaIn = 1'b1;
    hold(3);
    chk("R1 busy cleared by stop", busBusy, 1'b0);
    wrStat(1'b1);
    hold(5 * LIM);
    chk("R4 idle after stop", evtTimeout, 1'b0);

    // R10 limit of zero acts as one
    limitVal = '0;
    sdaIn = 1'b0; hold(1);
    sclIn = 1'b0;
    hold(4);
    chk("R10 zero limit edge 4", evtTimeout, 1'b0);
    hold(1);
    chk("R10 zero limit edge 5", evtTimeout, 1'b1);

    $display("  End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule